// File: doc/BRIEF.md
# Amplifier Command and Diagnostic Serial Target

This block is the two-wire serial target of a four-channel amplifier controller. A host writes two command bytes that set diagnostic enable, offset-check enable, the low-gain selects for the front and rear pairs, the mute releases, the standby release and the diagnostic threshold mode. These settings appear as registered output levels. A host read returns four status bytes, one for each channel. Each byte carries that channel's fault flags and some global flags.

The fault flags come from analog diagnostic blocks outside this one. A read latches them into a snapshot when the read address is accepted. The STOP that closes the read pulses a re-arm strobe, which tells those blocks to begin a new measurement cycle. Because of this, a read always reports the cycle that ran before it, and a change in a fault is first seen on the following read. The clock and data lines are oversampled by the system clock. They are synchronised and glitch-filtered before START, STOP and edges are detected.

Top module: `amp_ctl_i2c_target`

## Requirements
- R1: The target acknowledges only the address bytes 0xD8 (write) and 0xD9 (read), which are the 7-bit address 1101100 followed by the read/write bit. For any other address it leaves SDA released (NACK) and ignores the rest of the transaction.
- R2: The first byte after a write address sets these outputs: bit 6 drives diag_en_o, bit 5 drives offset_en_o, bit 4 drives gain_lo_front_o, bit 3 drives gain_lo_rear_o, bit 2 drives unmute_front_o and bit 1 drives unmute_rear_o. The target acknowledges the byte.
- R3: The second byte after a write address sets amp_on_o from bit 4 and line_mode_o from bit 3. The target acknowledges the byte.
- R4: Write bytes after the second are acknowledged and change no output.
- R5: A read returns bytes in channel order 0 (LF), 1 (LR), 2 (RF), 3 (RR), each sent MSB first. Bits 4:0 of byte k equal ch_flags_i[5k+4:5k], whose fields are: bit 4 permanent/turn-on, bit 3 shorted load, bit 2 open load or offset, bit 1 short to supply, bit 0 short to ground.
- R6: The global bits of the status bytes are: byte 0 bit 7 = thermal_warn_i and bit 6 = diag_done_i; byte 1 bit 7 = offset_active_i; byte 2 bit 7 = amp_on_o and bit 6 = diag_en_o. All other bits are 0.
- R7: The status bytes are captured when the read address is acknowledged. Input changes after that point do not appear until the next read.
- R8: rearm_o pulses for exactly one clock after the STOP that ends a read. A write transaction never pulses it.
- R9: After the master NACKs a read byte, the target does not drive SDA again until the next START.
- R10: A pulse on SCL or SDA lasting two system clocks or less is ignored.
- R11: After reset all command outputs are 0 (standby, muted, diagnostics off), SDA is released and rearm_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as sensed at the pin |
| sda_i | input | 1 | Serial data line as sensed at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| ch_flags_i | input | 20 | Five fault flags per channel, channel k at bits 5k+4:5k |
| thermal_warn_i | input | 1 | Thermal warning from the power stage |
| diag_done_i | input | 1 | The diagnostic cycle has terminated |
| offset_active_i | input | 1 | Offset detection is running |
| diag_en_o | output | 1 | Diagnostics enabled |
| offset_en_o | output | 1 | Offset detection enabled |
| gain_lo_front_o | output | 1 | Front pair at low gain |
| gain_lo_rear_o | output | 1 | Rear pair at low gain |
| unmute_front_o | output | 1 | Front pair unmuted |
| unmute_rear_o | output | 1 | Rear pair unmuted |
| amp_on_o | output | 1 | Out of standby |
| line_mode_o | output | 1 | Line-driver diagnostic thresholds selected |
| rearm_o | output | 1 | One-clock strobe that re-arms the diagnostic cycles |

## Verification
A bit counter that is off by one shifts every later bit. The fault shows up at the next acknowledge slot as a missing ACK, or as command outputs that no longer match the bench model once the bus goes idle. A wrong read index or a snapshot taken at the wrong time corrupts the very next status byte that is clocked out. A filter that lets a glitch through adds a phantom edge, which costs the ACK of the byte under way. A stale re-arm or parking flag shows up within one transaction, either as a pulse count that differs from the model or as SDA pulled low while the target should be silent.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_AACK = 3'd2,
        ST_WR   = 3'd3,
        ST_WACK = 3'd4,
        ST_RD   = 3'd5,
        ST_MACK = 3'd6,
        ST_PARK = 3'd7
    } tgt_state_e;

    localparam int BYTE_W    = 8;
    localparam int CMD_BYTES = 2;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FILT_LEN-1:0]    hist;
        logic                   out;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.sync = {f_q.sync[SYNC_STAGES-2:0], line_i};
        f_d.hist = {f_q.hist[FILT_LEN-2:0], f_q.sync[SYNC_STAGES-1]};
        if (&f_q.hist)
            f_d.out = 1'b1;
        else if (~|f_q.hist)
            f_d.out = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            f_q <= '1;
        else
            f_q <= f_d;
    end

    assign line_o = f_q.out;

    // R10: the filtered level only moves after a full window of agreeing samples
    a_r10_change_needs_agreement : assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.out != $past(f_q.out)) |-> ($past(f_q.hist) == {FILT_LEN{f_q.out}}));

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import amp_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6C,
    parameter int         IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl,
    input  logic             sda,
    input  logic [7:0]       rd_byte_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             rd_active_o,
    output logic             snap_o,
    output logic             wr_stb_o,
    output logic             wr_idx_o,
    output logic [5:0]       wr_data_o,
    output logic             rearm_o,
    output logic             sda_oe_o
);
    typedef struct packed {
        tgt_state_e       st;
        logic             scl_p;
        logic             sda_p;
        logic [3:0]       bitc;
        logic [7:0]       sh;
        logic [7:0]       tx;
        logic [IDX_W-1:0] idx;
        logic [1:0]       wcnt;
        logic             widx;
        logic             is_rd;
        logic             ack_drv;
        logic             mack;
        logic             wstb;
        logic             snap;
        logic             rearm;
    } eng_t;

    eng_t e_d, e_q;
    logic scl_rise, scl_fall, start_c, stop_c;

    always_comb begin
        scl_rise = scl & ~e_q.scl_p;
        scl_fall = ~scl & e_q.scl_p;
        start_c  = e_q.scl_p & scl & e_q.sda_p & ~sda;
        stop_c   = e_q.scl_p & scl & ~e_q.sda_p & sda;

        e_d       = e_q;
        e_d.scl_p = scl;
        e_d.sda_p = sda;
        e_d.wstb  = 1'b0;
        e_d.snap  = 1'b0;
        e_d.rearm = 1'b0;

        if (start_c) begin
            e_d.st      = ST_ADDR;
            e_d.bitc    = '0;
            e_d.ack_drv = 1'b0;
            e_d.is_rd   = 1'b0;
        end else if (stop_c) begin
            e_d.st      = ST_IDLE;
            e_d.ack_drv = 1'b0;
            e_d.rearm   = e_q.is_rd;
            e_d.is_rd   = 1'b0;
        end else begin
            unique case (e_q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise) begin
                        e_d.sh   = {e_q.sh[6:0], sda};
                        e_d.bitc = e_q.bitc + 4'd1;
                    end else if (scl_fall && e_q.bitc == 4'd8) begin
                        if (e_q.st == ST_WR) begin
                            e_d.wstb    = (e_q.wcnt != 2'd2);
                            e_d.widx    = e_q.wcnt[0];
                            e_d.wcnt    = (e_q.wcnt == 2'd2) ? e_q.wcnt : e_q.wcnt + 2'd1;
                            e_d.ack_drv = 1'b1;
                            e_d.st      = ST_WACK;
                        end else if (e_q.sh[7:1] == DEV_ADDR) begin
                            e_d.ack_drv = 1'b1;
                            e_d.st      = ST_AACK;
                            e_d.is_rd   = e_q.sh[0];
                            e_d.snap    = e_q.sh[0];
                            e_d.wcnt    = '0;
                            e_d.idx     = '0;
                        end else begin
                            e_d.st = ST_PARK;
                        end
                    end
                end
                ST_AACK, ST_WACK: begin
                    if (scl_fall) begin
                        e_d.ack_drv = 1'b0;
                        e_d.bitc    = '0;
                        if (e_q.is_rd) begin
                            e_d.tx = rd_byte_i;
                            e_d.st = ST_RD;
                        end else begin
                            e_d.st = ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        e_d.bitc = e_q.bitc + 4'd1;
                        e_d.tx   = {e_q.tx[6:0], 1'b0};
                        if (e_q.bitc == 4'd7)
                            e_d.st = ST_MACK;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        e_d.mack = ~sda;
                        e_d.idx  = e_q.idx + 1'b1;
                    end else if (scl_fall) begin
                        e_d.bitc = '0;
                        if (e_q.mack) begin
                            e_d.tx = rd_byte_i;
                            e_d.st = ST_RD;
                        end else begin
                            e_d.st = ST_PARK;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            e_q <= '0;
        else
            e_q <= e_d;
    end

    assign sda_oe_o    = e_q.ack_drv | ((e_q.st == ST_RD) & ~e_q.tx[7]);
    assign rd_idx_o    = e_q.idx;
    assign rd_active_o = (e_q.st == ST_RD) || (e_q.st == ST_MACK);
    assign snap_o      = e_q.snap;
    assign wr_stb_o    = e_q.wstb;
    assign wr_idx_o    = e_q.widx;
    assign wr_data_o   = e_q.sh[6:1];
    assign rearm_o     = e_q.rearm;

    // R8: the re-arm strobe is a single clock wide
    a_r8_rearm_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
        rearm_o |=> !rearm_o);

    // R8: the re-arm strobe only follows the end of a transaction
    a_r8_rearm_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
        rearm_o |-> (e_q.st == ST_IDLE));

    // R9: a parked target never pulls SDA
    a_r9_parked_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_PARK) |-> !sda_oe_o);

    // R1: an idle bus is never driven
    a_r1_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_IDLE) |-> !sda_oe_o);

    // R2: a command byte is committed only after eight data bits
    a_r2_commit_after_eight : assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (e_q.bitc == 4'd8));

endmodule

// File: rtl/amp_ctl_i2c_target.sv
module amp_ctl_i2c_target
    import amp_i2c_pkg::*;
#(
    parameter int         NUM_CH   = 4,
    parameter int         FLAG_W   = 5,
    parameter logic [6:0] DEV_ADDR = 7'h6C
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe_o,
    input  logic [NUM_CH*FLAG_W-1:0] ch_flags_i,
    input  logic                     thermal_warn_i,
    input  logic                     diag_done_i,
    input  logic                     offset_active_i,
    output logic                     diag_en_o,
    output logic                     offset_en_o,
    output logic                     gain_lo_front_o,
    output logic                     gain_lo_rear_o,
    output logic                     unmute_front_o,
    output logic                     unmute_rear_o,
    output logic                     amp_on_o,
    output logic                     line_mode_o,
    output logic                     rearm_o
);
    localparam int IDX_W = $clog2(NUM_CH);
    localparam int PAD_W = BYTE_W - FLAG_W;

    typedef struct packed {
        logic [5:0]                   ib1;
        logic [1:0]                   ib2;
        logic [NUM_CH-1:0][BYTE_W-1:0] snap;
    } cmd_t;

    cmd_t c_d, c_q;

    logic [1:0] raw_lines, clean_lines;
    logic [NUM_CH-1:0][BYTE_W-1:0] stat;
    logic [IDX_W-1:0] rd_idx;
    logic rd_active, snap_ld, wstb, widx;
    logic [5:0] wdat;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_glitch_filter #(.SYNC_STAGES(2), .FILT_LEN(3)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    i2c_target_engine #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl         (clean_lines[1]),
        .sda         (clean_lines[0]),
        .rd_byte_i   (c_q.snap[rd_idx]),
        .rd_idx_o    (rd_idx),
        .rd_active_o (rd_active),
        .snap_o      (snap_ld),
        .wr_stb_o    (wstb),
        .wr_idx_o    (widx),
        .wr_data_o   (wdat),
        .rearm_o     (rearm_o),
        .sda_oe_o    (sda_oe_o)
    );

    always_comb begin
        for (int k = 0; k < NUM_CH; k++)
            stat[k] = {{PAD_W{1'b0}}, ch_flags_i[k*FLAG_W +: FLAG_W]};
        stat[0][7] = thermal_warn_i;
        stat[0][6] = diag_done_i;
        stat[1][7] = offset_active_i;
        stat[2][7] = c_q.ib2[1];
        stat[2][6] = c_q.ib1[5];

        c_d = c_q;
        if (wstb) begin
            if (!widx)
                c_d.ib1 = wdat;
            else
                c_d.ib2 = wdat[3:2];
        end
        if (snap_ld)
            c_d.snap = stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= '0;
        else
            c_q <= c_d;
    end

    assign diag_en_o       = c_q.ib1[5];
    assign offset_en_o     = c_q.ib1[4];
    assign gain_lo_front_o = c_q.ib1[3];
    assign gain_lo_rear_o  = c_q.ib1[2];
    assign unmute_front_o  = c_q.ib1[1];
    assign unmute_rear_o   = c_q.ib1[0];
    assign amp_on_o        = c_q.ib2[1];
    assign line_mode_o     = c_q.ib2[0];

    // R7: the snapshot holds still while bytes are being shifted out
    a_r7_snapshot_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |=> $stable(c_q.snap));

    // R4: command state moves only on a committed first or second byte
    a_r4_cmd_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !wstb |=> $stable({c_q.ib1, c_q.ib2}));

endmodule

// File: tb/sim_amp_ctl_i2c_target.sv
module sim_amp_ctl_i2c_target;
    localparam int Q = 25;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [19:0] flags = '0;
    logic thermal = 1'b0, done = 1'b0, offs = 1'b0;
    logic sda_oe, diag_en, offset_en, g_f, g_r, um_f, um_r, amp_on, line_mode, rearm;
    wire sda_bus = sda_m & ~sda_oe;

    amp_ctl_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .ch_flags_i(flags), .thermal_warn_i(thermal), .diag_done_i(done),
        .offset_active_i(offs), .diag_en_o(diag_en), .offset_en_o(offset_en),
        .gain_lo_front_o(g_f), .gain_lo_rear_o(g_r), .unmute_front_o(um_f),
        .unmute_rear_o(um_r), .amp_on_o(amp_on), .line_mode_o(line_mode), .rearm_o(rearm)
    );

    int checks = 0, fails = 0, rearms = 0, quiet_viol = 0, cyc = 0;
    bit cmp_en = 0, watch_quiet = 0, finished = 0;
    logic [7:0] m_ib1 = '0, m_ib2 = '0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int k);
        case (k)
            0: return {thermal, done, 1'b0, flags[4:0]};
            1: return {offs, 2'b00, flags[9:5]};
            2: return {m_ib2[4], m_ib1[6], 1'b0, flags[14:10]};
            default: return {3'b000, flags[19:15]};
        endcase
    endfunction

    // reference model compared every clock while the bus is idle (R2, R3, R1)
    always @(negedge clk) begin
        cyc++;
        if (rearm) rearms++;
        if (watch_quiet && sda_oe) quiet_viol++;
        if (cmp_en) begin
            chk({diag_en, offset_en, g_f, g_r, um_f, um_r, amp_on, line_mode} ==
                {m_ib1[6:1], m_ib2[4:3]}, "R2/R3", "command outputs",
                {diag_en, offset_en, g_f, g_r, um_f, um_r, amp_on, line_mode},
                {m_ib1[6:1], m_ib2[4:3]});
            chk(!sda_oe, "R1", "idle sda_oe", sda_oe, 0);
        end
        if (cyc == 190000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        cmp_en = 0;
        sda_m = 1; scl_m = 1; hold(Q);
        sda_m = 0; hold(Q);
        scl_m = 0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; hold(Q);
        scl_m = 1; hold(Q);
        sda_m = 1; hold(Q + 12);
        cmp_en = 1;
    endtask

    task automatic put_bit(logic b, bit glitch);
        sda_m = b;
        if (glitch) begin
            hold(5); scl_m = 1; hold(2); scl_m = 0; hold(Q - 7);
        end else hold(Q);
        scl_m = 1;
        if (glitch && b) begin
            hold(Q); sda_m = 0; hold(2); sda_m = 1; hold(Q - 2);
        end else hold(2 * Q);
        scl_m = 0; hold(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1; hold(Q);
        scl_m = 1; hold(Q);
        b = sda_bus; hold(Q);
        scl_m = 0; hold(Q);
    endtask

    task automatic put_byte(logic [7:0] v, bit glitch, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
        get_bit(b);
        ack = !b;
    endtask

    task automatic get_byte(bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack, 0);
    endtask

    task automatic do_write(logic [7:0] b1, logic [7:0] b2, bit glitch);
        bit a;
        bus_start();
        put_byte(8'hD8, glitch, a); chk(a, "R1", "write address ack", a, 1);
        put_byte(b1, glitch, a);    chk(a, "R2", "first byte ack", a, 1);
        m_ib1 = b1;
        put_byte(b2, glitch, a);    chk(a, "R3", "second byte ack", a, 1);
        m_ib2 = b2;
        bus_stop();
    endtask

    task automatic do_read_check(string req);
        bit a;
        logic [7:0] v;
        logic [7:0] e [4];
        int r0;
        r0 = rearms;
        for (int k = 0; k < 4; k++) e[k] = exp_byte(k);
        bus_start();
        put_byte(8'hD9, 0, a); chk(a, "R1", "read address ack", a, 1);
        for (int k = 0; k < 4; k++) begin
            get_byte(k != 3, v);
            chk(v == e[k], req, $sformatf("status byte %0d", k), v, e[k]);
        end
        bus_stop();
        chk(rearms == r0 + 1, "R8", "rearm after read", rearms - r0, 1);
    endtask

    initial begin
        bit a;
        logic [7:0] v;
        logic [7:0] e [4];
        int r0;

        hold(10);
        rst_n = 1;
        hold(10);
        // R11: reset state
        chk({diag_en, offset_en, g_f, g_r, um_f, um_r, amp_on, line_mode} == 8'h00,
            "R11", "reset outputs", {diag_en, offset_en, g_f, g_r, um_f, um_r, amp_on, line_mode}, 0);
        chk(!sda_oe, "R11", "reset sda_oe", sda_oe, 0);
        chk(!rearm, "R11", "reset rearm", rearm, 0);
        cmp_en = 1;

        // R2 R3: several command patterns
        do_write(8'h7E, 8'h18, 0);
        do_write(8'h54, 8'h10, 0);
        r0 = rearms;
        do_write(8'h2A, 8'h08, 0);
        chk(rearms == r0, "R8", "no rearm after write", rearms - r0, 0);

        // R4: extra bytes acknowledged and ignored
        bus_start();
        put_byte(8'hD8, 0, a); chk(a, "R4", "address ack", a, 1);
        put_byte(8'h28, 0, a); m_ib1 = 8'h28;
        put_byte(8'h08, 0, a); m_ib2 = 8'h08;
        put_byte(8'hFE, 0, a); chk(a, "R4", "third byte ack", a, 1);
        put_byte(8'hFF, 0, a); chk(a, "R4", "fourth byte ack", a, 1);
        bus_stop();
        chk({diag_en, um_f, amp_on} == 3'b000, "R4", "extra bytes ignored",
            {diag_en, um_f, amp_on}, 0);

        // R1: foreign addresses NACKed, payload ignored
        bus_start();
        put_byte(8'hA0, 0, a); chk(!a, "R1", "nack 0xA0", a, 0);
        put_byte(8'hFE, 0, a); chk(!a, "R1", "no ack after foreign address", a, 0);
        bus_stop();
        bus_start();
        put_byte(8'hDA, 0, a); chk(!a, "R1", "nack 0xDA", a, 0);
        bus_stop();

        // R5 R6: read with global bits set
        do_write(8'h40, 8'h10, 0);
        flags = {5'h0C, 5'h13, 5'h0A, 5'h15};
        thermal = 1; done = 0; offs = 1;
        do_read_check("R5/R6");
        flags = {5'h1F, 5'h00, 5'h11, 5'h02};
        thermal = 0; done = 1; offs = 0;
        do_read_check("R5/R6");

        // R7: inputs changed after the address do not reach this read
        for (int k = 0; k < 4; k++) e[k] = exp_byte(k);
        bus_start();
        put_byte(8'hD9, 0, a); chk(a, "R7", "read address ack", a, 1);
        flags = {5'h03, 5'h18, 5'h07, 5'h19};
        thermal = 1; done = 0; offs = 1;
        for (int k = 0; k < 4; k++) begin
            get_byte(k != 3, v);
            chk(v == e[k], "R7", $sformatf("frozen byte %0d", k), v, e[k]);
        end
        bus_stop();
        do_read_check("R7");

        // R9: master NACK after the first byte, then more clocks
        flags[9:5] = 5'h00; offs = 0;
        r0 = rearms;
        bus_start();
        put_byte(8'hD9, 0, a); chk(a, "R9", "read address ack", a, 1);
        get_byte(0, v);
        chk(v == exp_byte(0), "R9", "byte before nack", v, exp_byte(0));
        watch_quiet = 1;
        get_byte(0, v);
        watch_quiet = 0;
        chk(v == 8'hFF, "R9", "released bus after nack", v, 8'hFF);
        chk(quiet_viol == 0, "R9", "sda_oe cycles after nack", quiet_viol, 0);
        bus_stop();
        chk(rearms == r0 + 1, "R8", "rearm after cut-short read", rearms - r0, 1);

        // R10: two-clock glitches on both lines during a write
        do_write(8'h2A, 8'h18, 1);
        chk({offset_en, g_r, um_r, amp_on, line_mode} == 5'b11111, "R10",
            "outputs after glitched write", {offset_en, g_r, um_r, amp_on, line_mode}, 5'b11111);

        hold(20);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule